// File: doc/BRIEF.md
# Pseudorandom Pattern Generator and Response Signature Compressor

This block is a self-test engine built around one 4-bit linear feedback shift register. Used as a generator, it steps through a fixed pseudorandom order of nonzero 4-bit patterns that drive a circuit under test. Used as a compressor, it folds that circuit's responses into a 4-bit signature. The responses can arrive as one serial bit per clock or as four parallel bits per clock.

A single load strobe writes the seed and arms a run length. The register then steps once per clock until the run count is used up. At that point the block raises a completion flag and reports whether the final register value equals an expected signature supplied at the ports. The mode input is sampled on every clock, so a run may switch modes as it goes. A fourth mode freezes the register while the count continues.

Top module: `bist_lfsr_engine`

## Requirements
- R1: In generator mode (mode code 2'b00), each step moves stage i+1 into stage i for i = 0..2 and loads stage 3 with stage3 XOR stage0. Both response inputs are ignored in this mode.
- R2: Seeded with 4'b1000 in generator mode, the register visits 15 distinct nonzero values and returns to 4'b1000 on the 15th step.
- R3: The register resets to 4'b1000. A zero seed loaded while the mode is generator is replaced by 4'b1000.
- R4: In serial compression mode (code 2'b01), stage 3 receives stage3 XOR stage0 XOR the serial response bit, the other stages shift as in R1, and the parallel response bits are ignored.
- R5: In parallel compression mode (code 2'b10), the result of the R1 step has response bit i XORed into stage i for every i, and the serial response bit is ignored.
- R6: A load writes the seed unchanged (a zero seed included, outside generator mode), clears the completion flag, and restarts the run even when a run is in progress. The loaded value is visible the cycle after the load.
- R7: In hold mode (code 2'b11), the register keeps its value while the run count still advances.
- R8: A load with run length N > 0 gives exactly N steps on the N clocks after the load. After the Nth step, busy is low and done is high. With N = 0, done rises on the load clock itself and no step takes place.
- R9: When done rises, match is 1 exactly when the register equals the expected input sampled on that clock. Done, match and the register then hold until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Seed and arm strobe |
| seed_i | input | 4 | Initial register value |
| mode_i | input | 2 | 00 generate, 01 serial compress, 10 parallel compress, 11 hold |
| run_len_i | input | 8 | Number of steps in the run, sampled on load |
| expect_i | input | 4 | Expected final signature |
| resp_ser_i | input | 1 | Serial response bit |
| resp_par_i | input | 4 | Parallel response bits, bit i into stage i |
| sig_o | output | 4 | Current pattern or signature |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| match_o | output | 1 | Final signature equals expected |

## Verification
The seed appears on sig_o one clock after the load edge. Each following clock edge applies one step, so the bench predicts the value after k steps exactly k clocks after the load. Done and match for a run of N are due N clocks after the load, and on the load clock itself when N is 0. The bench drives inputs and samples outputs at falling edges, so every expected value is read half a period after the edge that produced it, from an arithmetic model of the step rule.

// File: rtl/bist_pkg.sv
package bist_pkg;
   typedef enum logic [1:0] {
      MODE_GEN  = 2'b00,
      MODE_SER  = 2'b01,
      MODE_PAR  = 2'b10,
      MODE_HOLD = 2'b11
   } bist_mode_e;
endpackage

// File: rtl/bist_lfsr_core.sv
module bist_lfsr_core
   import bist_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   input  logic             step_i,
   input  bist_mode_e       mode_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] state_o,
   output logic [WIDTH-1:0] next_o,
   output logic [WIDTH-1:0] load_val_o
);
   localparam logic [WIDTH-1:0] SAFE_SEED = WIDTH'(1) << (WIDTH-1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bist_lfsr_core: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] shifted;
   logic             fb;

   always_comb begin
      fb = state_q[WIDTH-1] ^ state_q[0];
      if (mode_i == MODE_SER) fb = fb ^ ser_i;
   end

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH-1; gi++) begin : g_shift
         assign shifted[gi] = state_q[gi+1];
      end
   endgenerate
   assign shifted[WIDTH-1] = fb;

   always_comb begin
      unique case (mode_i)
         MODE_GEN, MODE_SER: next_o = shifted;
         MODE_PAR:           next_o = shifted ^ par_i;
         default:            next_o = state_q;
      endcase
   end

   assign load_val_o = (seed_i == '0 && mode_i == MODE_GEN) ? SAFE_SEED : seed_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= SAFE_SEED;
      else if (load_i) state_q <= load_val_o;
      else if (step_i) state_q <= next_o;
   end

   assign state_o = state_q;

   p_gen_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_GEN && state_q != '0) |=> state_q != '0);
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_HOLD && !load_i) |=> $stable(state_q));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/bist_run_counter.sv
module bist_run_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o,
   output logic             last_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("bist_run_counter: CNT_W must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= len_i;
         busy_q <= (len_i != '0);
      end else if (busy_q) begin
         cnt_q  <= cnt_q - ONE;
         if (cnt_q == ONE) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign last_o = busy_q && (cnt_q == ONE);

   p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !load_i) |=> cnt_q == CNT_W'($past(cnt_q) - ONE));
   p_busy_has_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> cnt_q != '0);
endmodule

// File: rtl/bist_lfsr_engine.sv
module bist_lfsr_engine
   import bist_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] run_len_i,
   input  logic [WIDTH-1:0] expect_i,
   input  logic             resp_ser_i,
   input  logic [WIDTH-1:0] resp_par_i,
   output logic [WIDTH-1:0] sig_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             match_o
);
   bist_mode_e       mode;
   logic             busy, last;
   logic [WIDTH-1:0] next_val, load_val;
   logic             done_q, match_q;

   assign mode = bist_mode_e'(mode_i);

   bist_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .len_i  (run_len_i),
      .busy_o (busy),
      .last_o (last)
   );

   bist_lfsr_core #(.WIDTH(WIDTH)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .seed_i     (seed_i),
      .step_i     (busy),
      .mode_i     (mode),
      .ser_i      (resp_ser_i),
      .par_i      (resp_par_i),
      .state_o    (sig_o),
      .next_o     (next_val),
      .load_val_o (load_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         match_q <= 1'b0;
      end else if (load_i) begin
         done_q  <= (run_len_i == '0);
         match_q <= (run_len_i == '0) && (load_val == expect_i);
      end else if (last) begin
         done_q  <= 1'b1;
         match_q <= (next_val == expect_i);
      end
   end

   assign busy_o  = busy;
   assign done_o  = done_q;
   assign match_o = match_q;

   p_done_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done_q));
   p_load_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && seed_i != '0) |=> sig_o == $past(seed_i));
   p_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (match_q == (sig_o == $past(expect_i))));
   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !load_i) |=> (done_q && $stable(match_q)));
endmodule

// File: tb/tb_bist_lfsr_engine.sv
module tb_bist_lfsr_engine;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [3:0] seed = '0;
   logic [1:0] mode = '0;
   logic [7:0] run_len = '0;
   logic [3:0] expv = '0;
   logic       rser = 1'b0;
   logic [3:0] rpar = '0;
   logic [3:0] sig;
   logic       busy, done, match;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bist_lfsr_engine dut (
      .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed), .mode_i(mode),
      .run_len_i(run_len), .expect_i(expv), .resp_ser_i(rser), .resp_par_i(rpar),
      .sig_o(sig), .busy_o(busy), .done_o(done), .match_o(match)
   );

   function automatic logic [3:0] mstep(input logic [3:0] s, input logic [1:0] m,
                                        input logic b, input logic [3:0] p);
      logic [3:0] n;
      if (m == 2'b11) return s;
      n = {s[3] ^ s[0] ^ ((m == 2'b01) ? b : 1'b0), s[3:1]};
      if (m == 2'b10) n = n ^ p;
      return n;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic start(input logic [3:0] sd, input logic [1:0] md,
                        input logic [7:0] len, input logic [3:0] ex);
      @(negedge clk);
      seed = sd; mode = md; run_len = len; expv = ex; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [3:0] m;
      logic [15:0] seen;
      int distinct;
      logic [19:0] stream;

      repeat (2) @(negedge clk);
      chk("R3 reset state", sig, 4'b1000);
      chk("R8 reset busy", busy, 0);
      chk("R9 reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2: full generator period, responses toggled but ignored
      start(4'b1000, 2'b00, 8'd15, 4'b1000);
      m = 4'b1000; seen = '0; distinct = 0;
      for (int k = 0; k < 15; k++) begin
         rser = k[0]; rpar = 4'(k * 5 + 1);
         if (!seen[m]) distinct++;
         seen[m] = 1'b1;
         @(negedge clk);
         m = mstep(m, 2'b00, 1'b0, 4'b0);
         chk("R1 generator step", sig, m);
      end
      chk("R2 distinct states", distinct, 15);
      chk("R2 period returns to 1000", sig, 4'b1000);
      chk("R2 no zero visited", seen[0], 0);
      chk("R8 done after 15", done, 1);
      chk("R8 busy low after run", busy, 0);
      chk("R9 match on expected", match, 1);

      // R9: register and flags hold while idle
      repeat (3) @(negedge clk);
      chk("R9 idle state hold", sig, 4'b1000);
      chk("R9 idle done hold", done, 1);

      // R3: zero seed in generator mode
      start(4'b0000, 2'b00, 8'd3, 4'b0);
      chk("R3 zero seed replaced", sig, 4'b1000);
      chk("R6 done cleared on load", done, 0);
      repeat (3) @(negedge clk);

      // R1: one step from every nonzero seed
      for (int s = 1; s < 16; s++) begin
         m = mstep(4'(s), 2'b00, 1'b0, 4'b0);
         start(4'(s), 2'b00, 8'd1, m);
         chk("R6 seed loaded", sig, s);
         @(negedge clk);
         chk("R1 single step", sig, m);
         chk("R9 single step match", match, 1);
      end

      // R4/R6: serial compression, zero seed kept
      stream = 20'hB3A5C;
      start(4'b0000, 2'b01, 8'd20, 4'b0);
      chk("R6 zero seed kept in compress", sig, 0);
      m = 4'b0000;
      for (int k = 0; k < 20; k++) begin
         rser = stream[k]; rpar = 4'(k * 3);
         @(negedge clk);
         m = mstep(m, 2'b01, stream[k], 4'b0);
         chk("R4 serial step", sig, m);
      end
      chk("R8 serial done", done, 1);
      chk("R9 serial match vs model", match, (m == 4'b0000) ? 1 : 0);

      // R5: parallel compression, matching then mismatching expected
      for (int pass = 0; pass < 2; pass++) begin
         logic [3:0] sigexp;
         sigexp = 4'b0101;
         for (int k = 0; k < 16; k++)
            sigexp = mstep(sigexp, 2'b10, 1'b0, 4'(k * 7 + 3));
         start(4'b0101, 2'b10, 8'd16, (pass == 0) ? sigexp : (sigexp ^ 4'b0001));
         m = 4'b0101;
         for (int k = 0; k < 16; k++) begin
            rpar = 4'(k * 7 + 3); rser = ~k[0];
            @(negedge clk);
            m = mstep(m, 2'b10, 1'b0, 4'(k * 7 + 3));
            chk("R5 parallel step", sig, m);
         end
         chk("R5 parallel signature", sig, sigexp);
         chk("R9 parallel match flag", match, (pass == 0) ? 1 : 0);
      end

      // R7: hold mode
      start(4'b1001, 2'b11, 8'd5, 4'b1001);
      for (int k = 0; k < 5; k++) begin
         rser = 1'b1; rpar = 4'hF;
         @(negedge clk);
         chk("R7 hold keeps value", sig, 4'b1001);
      end
      chk("R7 hold run done", done, 1);
      chk("R7 hold match", match, 1);

      // R8: zero run length
      start(4'b0110, 2'b00, 8'd0, 4'b0110);
      chk("R8 zero length done", done, 1);
      chk("R8 zero length busy", busy, 0);
      chk("R8 zero length match", match, 1);
      @(negedge clk);
      chk("R8 zero length no step", sig, 4'b0110);
      start(4'b0110, 2'b00, 8'd0, 4'b0111);
      chk("R9 zero length mismatch", match, 0);

      // R6: reload during a run
      start(4'b1000, 2'b00, 8'd10, 4'b0);
      repeat (3) @(negedge clk);
      chk("R8 busy mid run", busy, 1);
      start(4'b0011, 2'b10, 8'd2, 4'b0);
      chk("R6 reload value", sig, 4'b0011);
      chk("R6 reload busy", busy, 1);
      chk("R6 reload done clear", done, 0);
      rpar = 4'b1010;
      m = mstep(4'b0011, 2'b10, 1'b0, 4'b1010);
      @(negedge clk);
      m = mstep(m, 2'b10, 1'b0, 4'b1010);
      @(negedge clk);
      chk("R6 reload run result", sig, m);
      chk("R8 reload run done", done, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule